// File: doc/BRIEF.md
# Hypervisor Coprocessor Trap Controller

This block holds the 32-bit trap control register that a hypervisor uses to take over floating-point, SIMD and coprocessor-access-control functions from guest software, and it turns that register into a per-access decision. Software reaches the register through a simple request port. Each request carries its privilege mode and its security state. Only the hypervisor and a monitor running with the secure-configuration NS bit set are let in. Any other request is refused: it reads zero and its write is lost.

Alongside the register port, the instruction pipeline presents one coprocessor or SIMD access at a time. An access is tagged with a function kind, a mode and a security state. The block answers with exactly one of three outcomes: the access proceeds, it traps to hypervisor mode, or it raises an undefined-instruction exception in hypervisor mode.

The non-secure access control bits come in as plain inputs. On a non-secure register access they force the matching trap bits to read as one and to ignore writes. The floating-point and SIMD implementation options are elaboration parameters, and they force the same bits for every requester.

Top module: `hyp_cp_trap_ctrl`

## Requirements
- R1: A read that is accepted (`req_write`=0) returns zeros on bits 30:16 and bit 14, ones on bits 13:12 and ones on bits 9:0. A refused read, or a cycle with no read, returns all zeros.
- R2: Mode encoding is 0=user (PL0), 1=supervisor (PL1), 2=hypervisor, 3=monitor. A request is accepted only from mode 2 with `req_ns`=1, or from mode 3 while `scr_ns`=1. Any other request raises `req_denied` in the same cycle, reads zero, and leaves the register unchanged.
- R3: After reset, trap bits 31, 15, 11 and 10 are zero, so a permitted non-secure read returns 0x000033FF.
- R4: An accepted write stores `req_wdata` bits 31 (access-control trap), 15 (SIMD trap), 11 (CP11 trap) and 10 (CP10 trap) at the next clock edge, unless R5 or R6 forces that bit.
- R5: On a request with `req_ns`=1, three bits read as one and ignore writes: bit 15 when `nsa_simd_off`=1, bit 10 when `nsa_cp10_en`=0, and bit 11 when `nsa_cp11_en`=0. A request with `req_ns`=0 reads and writes the stored values.
- R6: With HAS_SIMD=0, bit 15 reads as one and ignores writes for every requester. With both HAS_SIMD=0 and HAS_FP=0, bits 11 and 10 do the same.
- R7: Function kind encoding is 0=CP10, 1=CP11, 2=SIMD, 3=access-control register. A non-secure access from any mode other than hypervisor whose effective trap bit is one gives `fn_trap_hyp`. The effective bit is the stored bit forced by R5 (non-secure view) and R6.
- R8: A non-secure hypervisor-mode access to CP10, CP11 or SIMD whose effective trap bit is one gives `fn_undef`. A hypervisor access to the access-control register always proceeds.
- R9: CP10 and CP11 accesses count as trapped when either bit 10 or bit 11 is effectively one. A SIMD access counts as trapped when bit 15, bit 10 or bit 11 is effectively one.
- R10: An access with `fn_ns`=0 always proceeds. While `fn_valid`=1 exactly one of `fn_proceed`, `fn_trap_hyp` and `fn_undef` is high. While `fn_valid`=0 all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | Requester privilege mode |
| req_ns | input | 1 | Requester is non-secure |
| req_wdata | input | 32 | Write data |
| scr_ns | input | 1 | Secure-configuration NS bit |
| nsa_simd_off | input | 1 | Non-secure SIMD use disabled |
| nsa_cp10_en | input | 1 | Non-secure CP10 use enabled |
| nsa_cp11_en | input | 1 | Non-secure CP11 use enabled |
| fn_valid | input | 1 | Function access present |
| fn_kind | input | 2 | Function kind |
| fn_mode | input | 2 | Mode of the function access |
| fn_ns | input | 1 | Function access is non-secure |
| req_denied | output | 1 | Register request refused |
| rd_data | output | 32 | Read data (combinational) |
| fn_proceed | output | 1 | Access proceeds |
| fn_trap_hyp | output | 1 | Access traps to hypervisor mode |
| fn_undef | output | 1 | Undefined-instruction exception in hypervisor mode |

## Verification
On every cycle the assertions check four things. Accepted reads keep the constant bit pattern. Refused requests read zero and never alter the stored trap bits. A write that the non-secure SIMD disable forbids leaves bit 15 alone. The outcome outputs stay one-hot while an access is present and silent otherwise; secure accesses always proceed, and hypervisor accesses never trap to hypervisor. The other behaviours show only in the bench's scenarios. These are the mode-by-function outcome table, the uneven CP10/CP11 setting, the split between the non-secure and secure views of a forced bit, and the forcing by the implementation options, which needs differently built instances.

// File: rtl/hcpt_pkg.sv
// Shared types and bit positions for the hypervisor coprocessor trap controller.
// Assumes a 32-bit register with four writable trap bits.
package hcpt_pkg;
    localparam int REG_W     = 32;
    localparam int POS_CPACR = 31;
    localparam int POS_SIMD  = 15;
    localparam int POS_CP11  = 11;
    localparam int POS_CP10  = 10;
    localparam int ONES_LO_W = 10;   // bits 9:0 read as one
    localparam int ONES_MID_LSB = 12;
    localparam int ONES_MID_W   = 2; // bits 13:12 read as one

    typedef enum logic [1:0] {
        MODE_USR = 2'd0,
        MODE_SVC = 2'd1,
        MODE_HYP = 2'd2,
        MODE_MON = 2'd3
    } pmode_e;

    typedef enum logic [1:0] {
        FN_CP10  = 2'd0,
        FN_CP11  = 2'd1,
        FN_SIMD  = 2'd2,
        FN_CPACR = 2'd3
    } fn_kind_e;

    typedef struct packed {
        logic cpacr;
        logic simd;
        logic cp11;
        logic cp10;
    } trap_bits_t;
endpackage

// File: rtl/hcpt_force.sv
// Works out which trap bits are pinned to one: by the implementation options
// (for every requester) and by the non-secure access control bits (applied
// by the callers only on non-secure views). Purely combinational.
module hcpt_force
    import hcpt_pkg::*;
#(
    parameter bit HAS_FP   = 1'b1,
    parameter bit HAS_SIMD = 1'b1
) (
    input  logic       nsa_simd_off,
    input  logic       nsa_cp10_en,
    input  logic       nsa_cp11_en,
    output trap_bits_t impl_force,
    output trap_bits_t ns_force
);
    // Implementation variant chosen at elaboration.
    generate
        if (!HAS_SIMD && !HAS_FP) begin : g_none
            assign impl_force = '{cpacr: 1'b0, simd: 1'b1, cp11: 1'b1, cp10: 1'b1};
        end else if (!HAS_SIMD) begin : g_fp_only
            assign impl_force = '{cpacr: 1'b0, simd: 1'b1, cp11: 1'b0, cp10: 1'b0};
        end else begin : g_full
            assign impl_force = '0;
        end
    endgenerate

    // Bits that non-secure access control denies.
    always_comb begin
        ns_force       = '0;
        ns_force.simd  = nsa_simd_off;
        ns_force.cp10  = ~nsa_cp10_en;
        ns_force.cp11  = ~nsa_cp11_en;
    end
endmodule

// File: rtl/hcpt_store.sv
// Holds the four writable trap bits. A write updates only the bits not
// pinned by wr_keep; pinned bits keep their stored value.
module hcpt_store
    import hcpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  trap_bits_t wr_bits,
    input  trap_bits_t wr_keep,
    output trap_bits_t q
);
    // Register update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= (q & wr_keep) | (wr_bits & ~wr_keep);
        end
    end
endmodule

// File: rtl/hcpt_decide.sv
// Combinational outcome for one coprocessor / SIMD / access-control access.
// Assumes the access is otherwise valid; only this register's traps apply.
module hcpt_decide
    import hcpt_pkg::*;
(
    input  logic       fn_valid,
    input  fn_kind_e   fn_kind,
    input  pmode_e     fn_mode,
    input  logic       fn_ns,
    input  trap_bits_t eff,
    output logic       proceed,
    output logic       trap_hyp,
    output logic       undef
);
    logic fp_trap;
    logic hit;

    // Uneven CP10/CP11 settings count as trapped.
    assign fp_trap = eff.cp10 | eff.cp11;

    // Select the trap bit governing this function kind.
    always_comb begin
        unique case (fn_kind)
            FN_CP10, FN_CP11: hit = fp_trap;
            FN_SIMD:          hit = eff.simd | fp_trap;
            default:          hit = eff.cpacr;
        endcase
    end

    // Pick exactly one outcome while an access is present.
    always_comb begin
        proceed  = 1'b0;
        trap_hyp = 1'b0;
        undef    = 1'b0;
        if (fn_valid) begin
            if (!fn_ns || !hit) begin
                proceed = 1'b1;
            end else if (fn_mode == MODE_HYP) begin
                if (fn_kind == FN_CPACR) proceed = 1'b1;
                else                     undef   = 1'b1;
            end else begin
                trap_hyp = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hyp_cp_trap_ctrl.sv
// Hypervisor coprocessor trap controller: register access gating, read view
// assembly, trap-bit storage and per-access outcome. Reads are combinational;
// writes take effect at the next clock edge.
module hyp_cp_trap_ctrl
    import hcpt_pkg::*;
#(
    parameter bit HAS_FP   = 1'b1,
    parameter bit HAS_SIMD = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_mode,
    input  logic              req_ns,
    input  logic [REG_W-1:0]  req_wdata,
    input  logic              scr_ns,
    input  logic              nsa_simd_off,
    input  logic              nsa_cp10_en,
    input  logic              nsa_cp11_en,
    input  logic              fn_valid,
    input  logic [1:0]        fn_kind,
    input  logic [1:0]        fn_mode,
    input  logic              fn_ns,
    output logic              req_denied,
    output logic [REG_W-1:0]  rd_data,
    output logic              fn_proceed,
    output logic              fn_trap_hyp,
    output logic              fn_undef
);
    trap_bits_t impl_force, ns_force, req_pin, trap_q, view, eff;
    trap_bits_t wr_bits;
    logic       allowed, accept;
    pmode_e     rmode;

    assign rmode = pmode_e'(req_mode);

    // Access gate: hypervisor non-secure, or monitor with NS set.
    assign allowed    = ((rmode == MODE_HYP) && req_ns) ||
                        ((rmode == MODE_MON) && scr_ns);
    assign accept     = req_valid && allowed;
    assign req_denied = req_valid && !allowed;

    hcpt_force #(.HAS_FP(HAS_FP), .HAS_SIMD(HAS_SIMD)) u_force (
        .nsa_simd_off (nsa_simd_off),
        .nsa_cp10_en  (nsa_cp10_en),
        .nsa_cp11_en  (nsa_cp11_en),
        .impl_force   (impl_force),
        .ns_force     (ns_force)
    );

    // Bits pinned for this requester's view.
    assign req_pin = impl_force | (req_ns ? ns_force : trap_bits_t'('0));

    // Extract writable fields from write data.
    always_comb begin
        wr_bits.cpacr = req_wdata[POS_CPACR];
        wr_bits.simd  = req_wdata[POS_SIMD];
        wr_bits.cp11  = req_wdata[POS_CP11];
        wr_bits.cp10  = req_wdata[POS_CP10];
    end

    hcpt_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept && req_write),
        .wr_bits (wr_bits),
        .wr_keep (req_pin),
        .q       (trap_q)
    );

    assign view = trap_q | req_pin;

    // Assemble the read word; zero unless an accepted read.
    always_comb begin
        rd_data = '0;
        if (accept && !req_write) begin
            rd_data[ONES_LO_W-1:0]                        = '1;
            rd_data[ONES_MID_LSB+ONES_MID_W-1:ONES_MID_LSB] = '1;
            rd_data[POS_CPACR] = view.cpacr;
            rd_data[POS_SIMD]  = view.simd;
            rd_data[POS_CP11]  = view.cp11;
            rd_data[POS_CP10]  = view.cp10;
        end
    end

    // Functions are judged on the non-secure view of the trap bits.
    assign eff = trap_q | impl_force | ns_force;

    hcpt_decide u_decide (
        .fn_valid (fn_valid),
        .fn_kind  (fn_kind_e'(fn_kind)),
        .fn_mode  (pmode_e'(fn_mode)),
        .fn_ns    (fn_ns),
        .eff      (eff),
        .proceed  (fn_proceed),
        .trap_hyp (fn_trap_hyp),
        .undef    (fn_undef)
    );
endmodule

// File: rtl/hcpt_checker.sv
// Property checker for hyp_cp_trap_ctrl, attached by bind. Observes ports
// and the stored trap bits.
module hcpt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic        req_ns,
    input logic [31:0] req_wdata,
    input logic        nsa_simd_off,
    input logic        req_denied,
    input logic [31:0] rd_data,
    input logic        fn_valid,
    input logic [1:0]  fn_mode,
    input logic        fn_ns,
    input logic        fn_proceed,
    input logic        fn_trap_hyp,
    input logic        fn_undef,
    input logic [3:0]  trap_q
);
    a_r1_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_denied && !req_write) |->
        (rd_data[30:16] == 15'd0 && !rd_data[14] && rd_data[13:12] == 2'b11 &&
         rd_data[9:0] == 10'h3FF));

    a_r2_refused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_denied) |-> (rd_data == 32'd0));

    a_r2_refused_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_denied) |=> $stable(trap_q));

    a_r4_cpacr_bit_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_denied && req_write) |=> (trap_q[3] == $past(req_wdata[31])));

    a_r5_simd_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_denied && req_write && req_ns && nsa_simd_off) |=> $stable(trap_q[2]));

    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        fn_valid |-> $onehot({fn_proceed, fn_trap_hyp, fn_undef}));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fn_valid |-> ({fn_proceed, fn_trap_hyp, fn_undef} == 3'b000));

    a_r10_secure_proceeds: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_valid && !fn_ns) |-> fn_proceed);

    a_r8_hyp_no_hyp_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_valid && fn_mode == 2'd2) |-> !fn_trap_hyp);
endmodule

bind hyp_cp_trap_ctrl hcpt_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_ns       (req_ns),
    .req_wdata    (req_wdata),
    .nsa_simd_off (nsa_simd_off),
    .req_denied   (req_denied),
    .rd_data      (rd_data),
    .fn_valid     (fn_valid),
    .fn_mode      (fn_mode),
    .fn_ns        (fn_ns),
    .fn_proceed   (fn_proceed),
    .fn_trap_hyp  (fn_trap_hyp),
    .fn_undef     (fn_undef),
    .trap_q       (trap_q)
);

// File: tb/sim_hyp_cp_trap_ctrl.sv
`timescale 1ns/1ps
module sim_hyp_cp_trap_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, req_ns = 0, scr_ns = 0;
    logic [1:0] req_mode = 0;
    logic [31:0] req_wdata = 0;
    logic nsa_simd_off = 0, nsa_cp10_en = 1, nsa_cp11_en = 1;
    logic fn_valid = 0, fn_ns = 0;
    logic [1:0] fn_kind = 0, fn_mode = 0;

    logic        den0, den1, den2;
    logic [31:0] rd0, rd1, rd2;
    logic        p0, t0, u0x, p1, t1, u1x, p2, t2, u2x;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    hyp_cp_trap_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_mode(req_mode), .req_ns(req_ns), .req_wdata(req_wdata), .scr_ns(scr_ns),
        .nsa_simd_off(nsa_simd_off), .nsa_cp10_en(nsa_cp10_en), .nsa_cp11_en(nsa_cp11_en),
        .fn_valid(fn_valid), .fn_kind(fn_kind), .fn_mode(fn_mode), .fn_ns(fn_ns),
        .req_denied(den0), .rd_data(rd0), .fn_proceed(p0), .fn_trap_hyp(t0), .fn_undef(u0x));

    hyp_cp_trap_ctrl #(.HAS_FP(1'b0), .HAS_SIMD(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_mode(req_mode), .req_ns(req_ns), .req_wdata(req_wdata), .scr_ns(scr_ns),
        .nsa_simd_off(nsa_simd_off), .nsa_cp10_en(nsa_cp10_en), .nsa_cp11_en(nsa_cp11_en),
        .fn_valid(fn_valid), .fn_kind(fn_kind), .fn_mode(fn_mode), .fn_ns(fn_ns),
        .req_denied(den1), .rd_data(rd1), .fn_proceed(p1), .fn_trap_hyp(t1), .fn_undef(u1x));

    hyp_cp_trap_ctrl #(.HAS_FP(1'b1), .HAS_SIMD(1'b0)) u2 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_mode(req_mode), .req_ns(req_ns), .req_wdata(req_wdata), .scr_ns(scr_ns),
        .nsa_simd_off(nsa_simd_off), .nsa_cp10_en(nsa_cp10_en), .nsa_cp11_en(nsa_cp11_en),
        .fn_valid(fn_valid), .fn_kind(fn_kind), .fn_mode(fn_mode), .fn_ns(fn_ns),
        .req_denied(den2), .rd_data(rd2), .fn_proceed(p2), .fn_trap_hyp(t2), .fn_undef(u2x));

    // Vector: [11:8] traps {31,15,11,10}, [7:6] kind, [5:4] mode, [3] ns, [2:0] {undef,trap,proceed}
    localparam int NV = 16;
    localparam logic [11:0] VEC [NV] = '{
        {4'b0000, 2'd0, 2'd1, 1'b1, 3'b001},
        {4'b0011, 2'd0, 2'd1, 1'b1, 3'b010},
        {4'b0011, 2'd1, 2'd0, 1'b1, 3'b010},
        {4'b0011, 2'd0, 2'd2, 1'b1, 3'b100},
        {4'b0011, 2'd0, 2'd1, 1'b0, 3'b001},
        {4'b0100, 2'd2, 2'd1, 1'b1, 3'b010},
        {4'b0100, 2'd2, 2'd2, 1'b1, 3'b100},
        {4'b0100, 2'd0, 2'd1, 1'b1, 3'b001},
        {4'b1000, 2'd3, 2'd1, 1'b1, 3'b010},
        {4'b1000, 2'd3, 2'd2, 1'b1, 3'b001},
        {4'b1000, 2'd3, 2'd0, 1'b1, 3'b010},
        {4'b0001, 2'd1, 2'd1, 1'b1, 3'b010},
        {4'b0010, 2'd0, 2'd2, 1'b1, 3'b100},
        {4'b0001, 2'd2, 2'd1, 1'b1, 3'b010},
        {4'b0000, 2'd2, 2'd2, 1'b1, 3'b001},
        {4'b0111, 2'd3, 2'd1, 1'b1, 3'b001}
    };

    function automatic logic [31:0] mkw(input logic [3:0] t);
        logic [31:0] w;
        w = 32'd0;
        w[31] = t[3]; w[15] = t[2]; w[11] = t[1]; w[10] = t[0];
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] m, input logic ns, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_mode = m; req_ns = ns; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd_start(input logic [1:0] m, input logic ns);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_mode = m; req_ns = ns;
        #1;
    endtask

    task automatic fn_start(input logic [1:0] k, input logic [1:0] m, input logic ns);
        @(negedge clk);
        fn_valid = 1; fn_kind = k; fn_mode = m; fn_ns = ns;
        #1;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        scr_ns = 1;

        // R3 / R1: reset state through a permitted non-secure read
        rd_start(2'd2, 1'b1);
        chk("R3 reset read", rd0, 32'h0000_33FF);
        chk("R1 idle outcome", {29'd0, u0x, t0, p0}, 32'd0);
        req_valid = 0;

        // Table walk: R7 R8 R9 R10 outcomes
        for (int i = 0; i < NV; i++) begin
            wr(2'd3, 1'b0, mkw(VEC[i][11:8]));
            fn_start(VEC[i][7:6], VEC[i][5:4], VEC[i][3]);
            chk($sformatf("R7/R8/R9/R10 vec %0d", i), {29'd0, u0x, t0, p0},
                {29'd0, VEC[i][2:0]});
            fn_valid = 0;
        end

        // R4: hypervisor write of all ones lands
        wr(2'd2, 1'b1, 32'hFFFF_FFFF);
        rd_start(2'd2, 1'b1);
        chk("R4 write all ones", rd0, 32'h8000_BFFF);
        req_valid = 0;

        // R2: refused supervisor write, and refused read
        wr(2'd1, 1'b1, 32'h0);
        rd_start(2'd1, 1'b1);
        chk("R2 refused flag", {31'd0, den0}, 32'd1);
        chk("R2 refused read zero", rd0, 32'd0);
        req_valid = 0;
        rd_start(2'd2, 1'b1);
        chk("R2 register unchanged", rd0, 32'h8000_BFFF);
        req_valid = 0;

        // R2: monitor with NS clear refused
        scr_ns = 0;
        wr(2'd3, 1'b0, 32'h0);
        scr_ns = 1;
        rd_start(2'd3, 1'b0);
        chk("R2 monitor NS clear ignored", rd0, 32'h8000_BFFF);
        req_valid = 0;

        // R2: monitor with NS set accepted
        wr(2'd3, 1'b0, 32'h0);
        rd_start(2'd3, 1'b0);
        chk("R2 monitor NS set accepted", rd0, 32'h0000_33FF);
        req_valid = 0;

        // R5: non-secure forcing on reads, secure view unaffected
        nsa_cp10_en = 0; nsa_simd_off = 1;
        rd_start(2'd2, 1'b1);
        chk("R5 ns read forced", rd0, 32'h0000_B7FF);
        req_valid = 0;
        rd_start(2'd3, 1'b0);
        chk("R5 secure read stored", rd0, 32'h0000_33FF);
        req_valid = 0;

        // R5: non-secure write leaves forced bits alone
        nsa_simd_off = 0;
        wr(2'd3, 1'b0, 32'h0000_0400);
        wr(2'd2, 1'b1, 32'h0);
        rd_start(2'd3, 1'b0);
        chk("R5 ns write ignored bit10", rd0, 32'h0000_37FF);
        req_valid = 0;

        // R7: denied CP10 gives effective trap from PL1
        wr(2'd3, 1'b0, 32'h0);
        fn_start(2'd0, 2'd1, 1'b1);
        chk("R7 nsacr-forced trap", {29'd0, u0x, t0, p0}, 32'd2);
        fn_valid = 0;
        nsa_cp10_en = 1;

        // R6: implementation options force bits for every requester
        rd_start(2'd3, 1'b0);
        chk("R6 no fp no simd", rd1, 32'h0000_BFFF);
        chk("R6 fp only", rd2, 32'h0000_B3FF);
        req_valid = 0;
        fn_start(2'd0, 2'd1, 1'b1);
        chk("R6 no fp cp10 traps", {29'd0, u1x, t1, p1}, 32'd2);
        chk("R6 fp only cp10 proceeds", {29'd0, u2x, t2, p2}, 32'd1);
        fn_valid = 0;

        // R3: reset again clears stored bits
        wr(2'd2, 1'b1, 32'hFFFF_FFFF);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rd_start(2'd2, 1'b1);
        chk("R3 reset clears", rd0, 32'h0000_33FF);
        req_valid = 0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule